// File: doc/BRIEF.md
# One-Shot Pulse Timer Channel

This block is an up-counting timer with a single compare channel that produces exactly one period per trigger. While idle it holds its count. An active edge on the trigger input arms it, and the count then climbs from zero by one on every prescaler tick. When the count reaches the auto-reload value, the next tick wraps the count to zero. On that same tick the counter disarms itself, raises a one-cycle update pulse and waits for the next trigger edge.

A compare reference output is formed from the count and a compare value in one of four modes. The result passes through a two-stage pipeline before it reaches the pin. A fast-compare option removes this latency at the start of the pulse. In either PWM mode, the trigger edge drives the reference straight to the level it would take after the compare match, and it is held there until the counter stops.

Top module: `oneshot_timer`

## Requirements
- R1: A rising edge on `trig_i` while the counter is idle starts the counter. The count stays 0 in the edge cycle and begins to advance on the following clock.
- R2: While running, the count increases by exactly one on each clock where `tick_i` is high, and holds on clocks where `tick_i` is low.
- R3: A tick that finds the count equal to `reload_i` sets the count to 0 and stops the counter. The count then stays 0 until a new trigger edge.
- R4: `update_o` is high for exactly one clock cycle, starting on the clock edge where the count wraps to 0.
- R5: `mode_i` encodes the reference: 0 gives constant low, 1 gives constant high, 2 (PWM-A) gives high while count < `compare_i` and low otherwise, 3 (PWM-B) gives the inverse of PWM-A.
- R6: Without fast compare, `ref_o` after a clock edge shows the mode result for the count that was present two clock edges earlier.
- R7: With `fast_en_i` high and mode 2 or 3, `ref_o` takes its post-match level (low for mode 2, high for mode 3) from the clock after the starting trigger edge until the counter stops.
- R8: In modes 0 and 1, `fast_en_i` has no effect on `ref_o`.
- R9: Trigger edges that arrive while the counter is running are ignored. Holding `trig_i` high after a stop does not restart the counter.
- R10: During and after reset, the count is 0, `update_o` is 0, `ref_o` is 0 and the counter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler tick; the count advances only when this is high |
| trig_i | input | 1 | Trigger input; its rising edge starts a pulse |
| mode_i | input | 2 | Reference mode: 0 low, 1 high, 2 PWM-A, 3 PWM-B |
| fast_en_i | input | 1 | Fast compare enable |
| compare_i | input | CNT_W | Compare value |
| reload_i | input | CNT_W | Auto-reload value, the last count of the pulse |
| ref_o | output | 1 | Compare reference output |
| count_o | output | CNT_W | Current count |
| update_o | output | 1 | One-cycle pulse when the single period ends |

## Verification
Three cases are hard to reach from the ports.

- **Stale fast-compare state.** The output stage would have to leave its fast-compare hold behind while the compare pipeline is still draining the last counts of a pulse. To get there, the stimulus runs fast pulses back to back, with only a short idle gap between them.
- **Re-trigger during a run.** The stimulus toggles the trigger in the middle of a run. It also holds the trigger high across a wrap, so that a level-sensitive start would be caught.
- **Shortest pulse.** A reload of zero makes the wrap fall on the first tick after the start. This checks that the update pulse and the stop line up with the start.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;

   typedef enum logic [1:0] {
      REF_FORCE_LO = 2'd0,
      REF_FORCE_HI = 2'd1,
      REF_PWM_A    = 2'd2,
      REF_PWM_B    = 2'd3
   } ref_mode_e;

   function automatic logic is_pwm(input ref_mode_e m);
      return (m == REF_PWM_A) || (m == REF_PWM_B);
   endfunction

   // level the reference holds once the compare match has happened
   function automatic logic post_match_level(input ref_mode_e m);
      return (m == REF_PWM_B);
   endfunction

endpackage

// File: rtl/shot_trig_detect.sv
module shot_trig_detect #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic edge_o
);
   logic trig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= trig_i;
   end

   generate
      if (RISING) begin : g_rise
         assign edge_o = trig_i & ~trig_q;
      end else begin : g_fall
         assign edge_o = ~trig_i & trig_q;
      end
   endgenerate

endmodule

// File: rtl/shot_counter.sv
module shot_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             edge_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             run_o,
   output logic             launch_o,
   output logic             stop_o,
   output logic             update_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             upd_q;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("shot_counter: CNT_W must be at least 2");
      end
   endgenerate

   assign launch_o = edge_i & ~run_q;
   assign stop_o   = run_q & tick_i & (cnt_q == reload_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         upd_q <= 1'b0;
      end else begin
         upd_q <= stop_o;
         if (launch_o)    run_q <= 1'b1;
         else if (stop_o) run_q <= 1'b0;
         if (stop_o)                cnt_q <= '0;
         else if (run_q && tick_i)  cnt_q <= cnt_q + ONE;
      end
   end

   assign count_o  = cnt_q;
   assign run_o    = run_q;
   assign update_o = upd_q;

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick_i && cnt_q != reload_i) |=> (cnt_q == $past(cnt_q) + ONE));
   assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tick_i) |=> $stable(cnt_q));
   assert_wrap_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick_i && cnt_q == reload_i) |=> (cnt_q == '0 && !run_q));
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !edge_i) |=> ($stable(cnt_q) && !run_q));
   assert_update_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |=> !upd_q);
   assert_ignore_retrig_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !(tick_i && cnt_q == reload_i)) |=> run_q);
   assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && !run_q) |=> (run_q && $stable(cnt_q)));

endmodule

// File: rtl/shot_compare.sv
module shot_compare
   import pulse_timer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ref_mode_e        mode_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] compare_i,
   output logic             level_o
);
   logic             raw;
   logic [DEPTH-1:0] stg_q;
   logic [1:0]       warm_q;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("shot_compare: DEPTH must be at least 1");
      end
   endgenerate

   always_comb begin
      unique case (mode_i)
         REF_FORCE_LO: raw = 1'b0;
         REF_FORCE_HI: raw = 1'b1;
         REF_PWM_A:    raw = (count_i < compare_i);
         default:      raw = !(count_i < compare_i);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stg_q[0] <= 1'b0;
      else        stg_q[0] <= raw;
   end

   generate
      for (genvar i = 1; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q[i] <= 1'b0;
            else        stg_q[i] <= stg_q[i-1];
         end
      end
   endgenerate

   assign level_o = stg_q[DEPTH-1];

   // warm-up counter so the latency check never looks past reset
   always_ff @(posedge clk) begin
      if (!rst_n)             warm_q <= 2'd0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   assert_pwm_a_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == REF_PWM_A && count_i < compare_i) |=> stg_q[0]);
   assert_pwm_b_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == REF_PWM_B && count_i < compare_i) |=> !stg_q[0]);
   generate
      if (DEPTH == 2) begin : g_lat_chk
         assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd3) |-> (level_o == $past(raw, 2)));
      end
   endgenerate

endmodule

// File: rtl/shot_out_stage.sv
module shot_out_stage
   import pulse_timer_pkg::*;
#(
   parameter bit FAST_SUPPORT = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      launch_i,
   input  logic      stop_i,
   input  logic      fast_en_i,
   input  ref_mode_e mode_i,
   input  logic      level_i,
   output logic      ref_o
);
   logic hold;

   generate
      if (FAST_SUPPORT) begin : g_fast
         logic hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                     hold_q <= 1'b0;
            else if (launch_i && fast_en_i && is_pwm(mode_i)) hold_q <= 1'b1;
            else if (stop_i)                                hold_q <= 1'b0;
         end
         assign hold = hold_q;
      end else begin : g_plain
         assign hold = 1'b0;
      end
   endgenerate

   assign ref_o = hold ? post_match_level(mode_i) : level_i;

   generate
      if (FAST_SUPPORT) begin : g_fast_chk
         assert_fast_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (launch_i && fast_en_i && is_pwm(mode_i) && $stable(mode_i))
            |=> (ref_o == post_match_level(mode_i)));
      end
   endgenerate
   assert_force_modes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_i && !is_pwm(mode_i)) |=> !hold);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
   import pulse_timer_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int PIPE_DEPTH   = 2,
   parameter bit FAST_SUPPORT = 1'b1,
   parameter bit TRIG_RISING  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             trig_i,
   input  logic [1:0]       mode_i,
   input  logic             fast_en_i,
   input  logic [CNT_W-1:0] compare_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             ref_o,
   output logic [CNT_W-1:0] count_o,
   output logic             update_o
);
   ref_mode_e mode;
   logic      trig_edge;
   logic      run;
   logic      launch;
   logic      stop;
   logic      level;

   assign mode = ref_mode_e'(mode_i);

   shot_trig_detect #(.RISING(TRIG_RISING)) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig_i),
      .edge_o (trig_edge)
   );

   shot_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .edge_i   (trig_edge),
      .reload_i (reload_i),
      .count_o  (count_o),
      .run_o    (run),
      .launch_o (launch),
      .stop_o   (stop),
      .update_o (update_o)
   );

   shot_compare #(.CNT_W(CNT_W), .DEPTH(PIPE_DEPTH)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode),
      .count_i   (count_o),
      .compare_i (compare_i),
      .level_o   (level)
   );

   shot_out_stage #(.FAST_SUPPORT(FAST_SUPPORT)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch_i  (launch),
      .stop_i    (stop),
      .fast_en_i (fast_en_i),
      .mode_i    (mode),
      .level_i   (level),
      .ref_o     (ref_o)
   );

   assert_reset_state_R10: assert property (@(posedge clk)
      !rst_n |=> (count_o == '0 && !update_o && !ref_o && !run));

endmodule

// File: tb/oneshot_timer_test.sv
`timescale 1ns/1ps
module oneshot_timer_test;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_i = 1'b0;
   logic         trig_i = 1'b0;
   logic [1:0]   mode_i = 2'd0;
   logic         fast_en_i = 1'b0;
   logic [W-1:0] compare_i = '0;
   logic [W-1:0] reload_i = '0;
   logic         ref_o;
   logic [W-1:0] count_o;
   logic         update_o;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [W-1:0] cnt;
      logic         refv;
      logic         upd;
      string        tag;
   } exp_t;
   exp_t q[$];

   // reference model state
   logic [W-1:0] m_cnt = '0;
   logic m_run = 0, m_p0 = 0, m_p1 = 0, m_hold = 0, m_upd = 0, m_tprev = 0;
   string cur_tag = "R10";

   oneshot_timer #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trig_i(trig_i),
      .mode_i(mode_i), .fast_en_i(fast_en_i), .compare_i(compare_i),
      .reload_i(reload_i), .ref_o(ref_o), .count_o(count_o), .update_o(update_o)
   );

   always #2.5 clk = ~clk;

   function automatic logic mode_level(input logic [1:0] m, input logic [W-1:0] c,
                                       input logic [W-1:0] cmp);
      case (m)
         2'd0: return 1'b0;
         2'd1: return 1'b1;
         2'd2: return c < cmp;
         default: return !(c < cmp);
      endcase
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // driver: called at a negedge, drives inputs for the next posedge and
   // pushes the outputs the requirements predict after that edge
   task automatic step(input logic trg, input logic tck);
      logic rise, launch, stop, pwm;
      exp_t e;
      trig_i = trg;
      tick_i = tck;
      rise   = trg & !m_tprev;
      launch = rise & !m_run;
      stop   = m_run & tck & (m_cnt == reload_i);
      pwm    = mode_i[1];
      m_tprev = trg;
      m_p1 = m_p0;
      m_p0 = mode_level(mode_i, m_cnt, compare_i);
      if (launch && fast_en_i && pwm) m_hold = 1'b1;
      else if (stop)                  m_hold = 1'b0;
      m_upd = stop;
      if (stop)              m_cnt = '0;
      else if (m_run && tck) m_cnt = m_cnt + 1'b1;
      if (launch)    m_run = 1'b1;
      else if (stop) m_run = 1'b0;
      e.cnt  = m_cnt;
      e.refv = m_hold ? (mode_i == 2'd3) : m_p1;
      e.upd  = m_upd;
      e.tag  = cur_tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b1);
   endtask

   // monitor: compares one expected item per clock, 1 ns after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "count_o", int'(count_o), int'(e.cnt));
            check(e.tag, "ref_o", int'(ref_o), int'(e.refv));
            check(e.tag, "update_o", int'(update_o), int'(e.upd));
         end
      end
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: outputs during reset
      check("R10", "count_o in reset", int'(count_o), 0);
      check("R10", "ref_o in reset", int'(ref_o), 0);
      check("R10", "update_o in reset", int'(update_o), 0);
      rst_n = 1'b1;
      idle(3);

      // R1/R5/R6: PWM-A, compare 4, reload 99, no fast compare
      cur_tag = "R1/R5/R6";
      mode_i = 2'd2; compare_i = 16'd4; reload_i = 16'd99; fast_en_i = 1'b0;
      idle(3);
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);
      idle(106);

      // R7: PWM-A with fast compare
      cur_tag = "R7";
      fast_en_i = 1'b1;
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);
      idle(104);

      // R7: PWM-B with fast compare, short gap between two pulses
      mode_i = 2'd3; compare_i = 16'd3; reload_i = 16'd9;
      idle(3);
      step(1'b1, 1'b1); step(1'b0, 1'b1); idle(11);
      step(1'b1, 1'b1); step(1'b0, 1'b1); idle(14);

      // R2: tick every other cycle, PWM-B without fast compare
      cur_tag = "R2";
      fast_en_i = 1'b0; compare_i = 16'd2; reload_i = 16'd5;
      step(1'b1, 1'b0);
      for (int i = 0; i < 16; i++) step(1'b0, i[0]);
      idle(4);

      // R9: re-trigger during a run, and trigger held high over the wrap
      cur_tag = "R9";
      mode_i = 2'd2; compare_i = 16'd5; reload_i = 16'd7;
      step(1'b1, 1'b1); step(1'b0, 1'b1); step(1'b0, 1'b1);
      step(1'b1, 1'b1); step(1'b0, 1'b1); step(1'b1, 1'b1);
      for (int i = 0; i < 12; i++) step(1'b1, 1'b1);
      idle(4);

      // R8: fast compare has no effect in the constant modes
      cur_tag = "R8";
      fast_en_i = 1'b1; mode_i = 2'd1; reload_i = 16'd4;
      idle(3);
      step(1'b1, 1'b1); step(1'b0, 1'b1); idle(8);
      mode_i = 2'd0;
      idle(3);
      step(1'b1, 1'b1); step(1'b0, 1'b1); idle(8);

      // R3/R4: reload of zero, back-to-back starts
      cur_tag = "R3/R4";
      mode_i = 2'd2; compare_i = 16'd1; reload_i = 16'd0; fast_en_i = 1'b0;
      step(1'b1, 1'b1); step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b0, 1'b1);
      idle(4);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule